// File: doc/BRIEF.md
# USB host interrupt aggregator

This block gathers the interrupt sources of a USB host controller that is built as several functions, and it drives three shared, level-sensitive interrupt request lines. Each function reports three transaction events: completion of a descriptor that asked for an interrupt, a short packet, and a CRC or timeout error. Each function also reports one controller operation error that cannot be masked. An end-of-frame strobe and a writeback-done strobe from the memory path tell the block when the status of a frame's transactions has reached memory.

Transaction events are latched into a per-function shadow while the frame runs. At end of frame they move to a second holding stage. They enter the visible status register only when the writeback-done strobe for that frame arrives, so software never sees an interrupt ahead of the status in memory. Operation errors go straight into visible status. A software register port writes a per-function enable register and clears status bits with write-one-to-clear. The enable register gates only the transaction bits. Each function has a fixed request line and its own pin identification value. Where two functions share a line, the line is the OR of both functions' pending state.

A two-state frame controller sequences the deferral:
- FR_RUN: the frame is in progress. An end-of-frame strobe takes the transition "roll" to FR_WAIT_WB. A writeback-done strobe in this state is ignored.
- FR_WAIT_WB: a frame has ended and its writeback is outstanding.
  - A writeback-done strobe alone takes the transition "commit" back to FR_RUN.
  - A writeback-done strobe together with an end-of-frame strobe takes "commit and roll", which stays in FR_WAIT_WB.
  - An end-of-frame strobe alone takes "merge", which stays in FR_WAIT_WB and folds the newer frame into the outstanding one.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset every status bit and every enable bit is 0, and irq_a, irq_c and irq_d are low.
- R2: An operation error pulse on a function sets that function's status bit 3 at the next clock edge. The function's line goes high in the same cycle, whatever the enable register holds.
- R3: A short-packet event (status bit 1) or a CRC/timeout event (status bit 2) stays invisible in status until a frame end and then a writeback-done have both been seen. It appears at the edge that samples writeback-done.
- R4: A completion event sets status bit 0 only when the descriptor interrupt flag (ev_ioc) is high in the same cycle. Without that flag it has no effect.
- R5: A transaction status bit drives its function's line only when the matching enable bit is set. Enable bit 0 gates completion, bit 1 gates short packet and bit 2 gates CRC/timeout. Status latches whatever the enable holds, so setting the enable later asserts the line.
- R6: Writing with reg_sel=1 clears each status bit of the selected function whose reg_wdata bit is 1. A line stays high while any function routed to it still has an enabled pending bit.
- R7: Functions 0 and 3 drive irq_a, function 1 drives irq_d and function 2 drives irq_c. route_o reports the line per function as a 2-bit code: A=0, B=1, C=2, D=3.
- R8: A writeback-done strobe while no frame end is outstanding changes no status bit.
- R9: A transaction event that arrives after a frame end but before that frame's writeback-done belongs to the next frame. The pending writeback-done does not make it visible.
- R10: A second frame end while a writeback is still outstanding merges the newer frame into it. The single following writeback-done makes the events of both frames visible.
- R11: Each function reports a distinct pin identification value on pin_id_o, equal to its index plus one.
- R12: When a status bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | NUM_FUNC | Descriptor completion, one bit per function |
| ev_ioc | input | NUM_FUNC | Completed descriptor requested an interrupt |
| ev_short | input | NUM_FUNC | Short packet received |
| ev_crc | input | NUM_FUNC | CRC error or bus timeout |
| ev_operr | input | NUM_FUNC | Controller operation error (not maskable) |
| frame_end | input | 1 | Strobe marking the end of a frame |
| wb_done | input | 1 | Strobe: status of the ended frame written to memory |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = write enable register, 1 = write-one-to-clear status |
| reg_func | input | FUNC_W | Function selected by the write |
| reg_wdata | input | 4 | Write data (enable uses bits 2:0) |
| status_o | output | NUM_FUNC*4 | Visible status, function f at bits [4f+3:4f] |
| enable_o | output | NUM_FUNC*3 | Enable register, function f at bits [3f+2:3f] |
| pin_id_o | output | NUM_FUNC*3 | Pin identification value per function |
| route_o | output | NUM_FUNC*2 | Line code per function |
| irq_a | output | 1 | Request line A |
| irq_c | output | 1 | Request line C |
| irq_d | output | 1 | Request line D |

## Verification
The hardest case to reach is a frame end arriving while the previous frame's writeback is still outstanding, because it needs a particular overlap of two strobes and events. The stimulus raises an event in one frame and ends that frame. It then raises a second event during the wait and issues a second frame end before any writeback-done. After that, a single writeback-done must expose both events. A related sequence checks the handover between frames: an event is placed after a frame end but before the writeback-done, and it must stay hidden until the following frame completes.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int SRC_W = 4;   // per-function status width
    localparam int TX_W  = 3;   // maskable transaction sources

    localparam int BIT_DONE  = 0;
    localparam int BIT_SHORT = 1;
    localparam int BIT_CRC   = 2;
    localparam int BIT_OPERR = 3;

    typedef enum logic [1:0] {
        LINE_A = 2'd0,
        LINE_B = 2'd1,
        LINE_C = 2'd2,
        LINE_D = 2'd3
    } irq_line_e;

    typedef enum logic {
        FR_RUN     = 1'b0,
        FR_WAIT_WB = 1'b1
    } frame_state_e;

    function automatic irq_line_e route_of(input int f);
        unique case (f % 4)
            0:       return LINE_A;
            1:       return LINE_D;
            2:       return LINE_C;
            default: return LINE_A;
        endcase
    endfunction

endpackage

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic wb_done,
    output logic commit,
    output logic roll
);

    frame_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        roll    = 1'b0;
        unique case (state_q)
            FR_RUN: begin
                roll = frame_end;
                if (frame_end) state_d = FR_WAIT_WB;
            end
            FR_WAIT_WB: begin
                commit = wb_done;
                roll   = frame_end;
                if (wb_done && !frame_end) state_d = FR_RUN;
            end
            default: state_d = FR_RUN;
        endcase
    end

endmodule

// File: rtl/irq_func_slice.sv
module irq_func_slice
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic             ev_ioc,
    input  logic             ev_short,
    input  logic             ev_crc,
    input  logic             ev_operr,
    input  logic             commit,
    input  logic             roll,
    input  logic             en_wr,
    input  logic             clr_wr,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] status,
    output logic [TX_W-1:0]  enable,
    output logic             pending
);

    logic [TX_W-1:0] tx_ev;
    logic [TX_W-1:0] cur_q;
    logic [TX_W-1:0] held_q;
    logic [TX_W-1:0] commit_bits;
    logic [SRC_W-1:0] clr_mask;
    logic [SRC_W-1:0] set_mask;

    always_comb begin
        tx_ev            = '0;
        tx_ev[BIT_DONE]  = ev_done & ev_ioc;
        tx_ev[BIT_SHORT] = ev_short;
        tx_ev[BIT_CRC]   = ev_crc;
        commit_bits      = commit ? held_q : '0;
        clr_mask         = clr_wr ? wdata : '0;
        set_mask         = {ev_operr, commit_bits};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            held_q <= '0;
        end else begin
            if (commit)    held_q <= roll ? (cur_q | tx_ev) : '0;
            else if (roll) held_q <= held_q | cur_q | tx_ev;
            cur_q <= roll ? '0 : (cur_q | tx_ev);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_mask;
            if (en_wr) enable <= wdata[TX_W-1:0];
        end
    end

    assign pending = |(status & {1'b1, enable});

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import usb_irq_pkg::*;
#(
    parameter int NUM_FUNC = 4
) (
    input  logic [NUM_FUNC-1:0] pending,
    output logic                irq_a,
    output logic                irq_c,
    output logic                irq_d
);

    always_comb begin
        irq_a = 1'b0;
        irq_c = 1'b0;
        irq_d = 1'b0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            unique case (route_of(f))
                LINE_A:  irq_a = irq_a | pending[f];
                LINE_C:  irq_c = irq_c | pending[f];
                LINE_D:  irq_d = irq_d | pending[f];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
    import usb_irq_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int FUNC_W   = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_FUNC-1:0]       ev_done,
    input  logic [NUM_FUNC-1:0]       ev_ioc,
    input  logic [NUM_FUNC-1:0]       ev_short,
    input  logic [NUM_FUNC-1:0]       ev_crc,
    input  logic [NUM_FUNC-1:0]       ev_operr,
    input  logic                      frame_end,
    input  logic                      wb_done,
    input  logic                      reg_wr,
    input  logic                      reg_sel,
    input  logic [FUNC_W-1:0]         reg_func,
    input  logic [SRC_W-1:0]          reg_wdata,
    output logic [NUM_FUNC*SRC_W-1:0] status_o,
    output logic [NUM_FUNC*TX_W-1:0]  enable_o,
    output logic [NUM_FUNC*3-1:0]     pin_id_o,
    output logic [NUM_FUNC*2-1:0]     route_o,
    output logic                      irq_a,
    output logic                      irq_c,
    output logic                      irq_d
);

    logic                commit;
    logic                roll;
    logic [NUM_FUNC-1:0] pending;

    irq_frame_ctrl u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .wb_done   (wb_done),
        .commit    (commit),
        .roll      (roll)
    );

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        logic sel_here;
        assign sel_here = reg_wr && (reg_func == FUNC_W'(f));

        irq_func_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_done  (ev_done[f]),
            .ev_ioc   (ev_ioc[f]),
            .ev_short (ev_short[f]),
            .ev_crc   (ev_crc[f]),
            .ev_operr (ev_operr[f]),
            .commit   (commit),
            .roll     (roll),
            .en_wr    (sel_here && !reg_sel),
            .clr_wr   (sel_here && reg_sel),
            .wdata    (reg_wdata),
            .status   (status_o[f*SRC_W +: SRC_W]),
            .enable   (enable_o[f*TX_W +: TX_W]),
            .pending  (pending[f])
        );

        assign pin_id_o[f*3 +: 3] = 3'(f + 1);
        assign route_o[f*2 +: 2]  = route_of(f);
    end

    irq_line_router #(.NUM_FUNC(NUM_FUNC)) u_router (
        .pending (pending),
        .irq_a   (irq_a),
        .irq_c   (irq_c),
        .irq_d   (irq_d)
    );

endmodule

// File: rtl/usb_irq_aggregator_chk.sv
module usb_irq_aggregator_chk
    import usb_irq_pkg::*;
#(
    parameter int NUM_FUNC = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_FUNC-1:0]       ev_operr,
    input logic                      wb_done,
    input logic                      reg_wr,
    input logic [NUM_FUNC*SRC_W-1:0] status_o,
    input logic                      irq_a,
    input logic                      irq_c,
    input logic                      irq_d
);

    function automatic logic [NUM_FUNC*SRC_W-1:0] tx_mask();
        logic [NUM_FUNC*SRC_W-1:0] m;
        m = '0;
        for (int f = 0; f < NUM_FUNC; f++) m[f*SRC_W +: TX_W] = '1;
        return m;
    endfunction

    localparam logic [NUM_FUNC*SRC_W-1:0] TXM = tx_mask();

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_op
        // R2
        operr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_operr[f] |=> status_o[f*SRC_W + BIT_OPERR]);
    end

    // R2
    operr_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_operr) |=> (irq_a || irq_c || irq_d));

    // R3
    no_early_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_done |=> ((status_o & TXM & ~$past(status_o)) == '0));

    // R6
    line_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a && !reg_wr) |=> irq_a);

    // R6
    line_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_c && !reg_wr) |=> irq_c);

    // R6
    line_d_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_d && !reg_wr) |=> irq_d);

    // R5
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |-> (!irq_a && !irq_c && !irq_d));

endmodule

bind usb_irq_aggregator usb_irq_aggregator_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_operr (ev_operr),
    .wb_done  (wb_done),
    .reg_wr   (reg_wr),
    .status_o (status_o),
    .irq_a    (irq_a),
    .irq_c    (irq_c),
    .irq_d    (irq_d)
);

// File: tb/usb_irq_aggregator_bench.sv
module usb_irq_aggregator_bench;

    localparam int NF = 4;
    localparam int FW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] ev_done = '0, ev_ioc = '0, ev_short = '0, ev_crc = '0, ev_operr = '0;
    logic          frame_end = 1'b0, wb_done = 1'b0;
    logic          reg_wr = 1'b0, reg_sel = 1'b0;
    logic [FW-1:0] reg_func = '0;
    logic [3:0]    reg_wdata = '0;
    logic [NF*4-1:0] status_o;
    logic [NF*3-1:0] enable_o, pin_id_o;
    logic [NF*2-1:0] route_o;
    logic irq_a, irq_c, irq_d;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    usb_irq_aggregator #(.NUM_FUNC(NF)) u_usb_irq_aggregator (
        .clk(clk), .rst_n(rst_n),
        .ev_done(ev_done), .ev_ioc(ev_ioc), .ev_short(ev_short),
        .ev_crc(ev_crc), .ev_operr(ev_operr),
        .frame_end(frame_end), .wb_done(wb_done),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_func(reg_func), .reg_wdata(reg_wdata),
        .status_o(status_o), .enable_o(enable_o), .pin_id_o(pin_id_o), .route_o(route_o),
        .irq_a(irq_a), .irq_c(irq_c), .irq_d(irq_d)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] st(input int f);
        return status_o[f*4 +: 4];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        ev_done = '0; ev_ioc = '0; ev_short = '0; ev_crc = '0; ev_operr = '0;
        frame_end = 1'b0; wb_done = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input int f, input logic [3:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_func = FW'(f); reg_wdata = d;
        tick();
        clear_inputs();
    endtask

    task automatic strobe_fe(); frame_end = 1'b1; tick(); clear_inputs(); endtask
    task automatic strobe_wb(); wb_done = 1'b1; tick(); clear_inputs(); endtask

    task automatic t_reset();
        check("R1 status", status_o, '0);
        check("R1 enable", enable_o, '0);
        check("R1 lines", {irq_a, irq_c, irq_d}, 3'b000);
        for (int f = 0; f < NF; f++) check("R11 pin id", pin_id_o[f*3 +: 3], f + 1);
        check("R7 route codes", route_o, {2'd0, 2'd2, 2'd3, 2'd0});
    endtask

    task automatic t_operr();
        ev_operr[1] = 1'b1; tick(); clear_inputs();
        check("R2 status bit3", st(1), 4'b1000);
        check("R2 R7 line d unmasked", {irq_a, irq_c, irq_d}, 3'b001);
        reg_write(1'b1, 1, 4'b1000);
        check("R6 clear f1", st(1), 4'b0000);
        check("R6 line d low", irq_d, 1'b0);
    endtask

    task automatic t_defer();
        reg_write(1'b0, 0, 4'b0111);
        check("R5 enable write", enable_o[2:0], 3'b111);
        ev_short[0] = 1'b1; tick(); clear_inputs();
        check("R3 hidden in frame", st(0), 4'b0000);
        strobe_wb();
        check("R8 stray writeback", st(0), 4'b0000);
        strobe_fe();
        check("R3 hidden before writeback", st(0), 4'b0000);
        check("R3 line low before writeback", irq_a, 1'b0);
        ev_crc[0] = 1'b1; tick(); clear_inputs();
        strobe_wb();
        check("R3 R9 visible after writeback", st(0), 4'b0010);
        check("R7 line a", {irq_a, irq_c, irq_d}, 3'b100);
        strobe_fe();
        strobe_wb();
        check("R9 next frame commits", st(0), 4'b0110);
        reg_write(1'b1, 0, 4'b0110);
        check("R6 clear f0", irq_a, 1'b0);
    endtask

    task automatic t_ioc();
        ev_done[2] = 1'b1; tick(); clear_inputs();
        strobe_fe(); strobe_wb();
        check("R4 no flag ignored", st(2), 4'b0000);
        ev_done[2] = 1'b1; ev_ioc[2] = 1'b1; tick(); clear_inputs();
        strobe_fe(); strobe_wb();
        check("R4 flagged completion", st(2), 4'b0001);
        check("R5 masked line c", irq_c, 1'b0);
        reg_write(1'b0, 2, 4'b0001);
        check("R5 late enable asserts", irq_c, 1'b1);
        reg_write(1'b1, 2, 4'b0001);
        check("R6 clear f2", irq_c, 1'b0);
    endtask

    task automatic t_share();
        ev_operr[0] = 1'b1; ev_operr[3] = 1'b1; tick(); clear_inputs();
        check("R7 shared line a", irq_a, 1'b1);
        reg_write(1'b1, 0, 4'b1000);
        check("R6 R7 line a held by f3", irq_a, 1'b1);
        reg_write(1'b1, 3, 4'b1000);
        check("R6 line a released", irq_a, 1'b0);
    endtask

    task automatic t_merge();
        reg_write(1'b0, 1, 4'b0110);
        ev_short[1] = 1'b1; tick(); clear_inputs();
        strobe_fe();
        ev_crc[1] = 1'b1; tick(); clear_inputs();
        strobe_fe();
        check("R10 still hidden", st(1), 4'b0000);
        strobe_wb();
        check("R10 merged frames", st(1), 4'b0110);
        check("R10 line d", irq_d, 1'b1);
        strobe_fe(); strobe_wb();
        reg_write(1'b1, 1, 4'b0110);
        check("R6 clear f1 tx", st(1), 4'b0000);
    endtask

    task automatic t_setwins();
        ev_operr[3] = 1'b1; tick(); clear_inputs();
        ev_operr[3] = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_func = FW'(3); reg_wdata = 4'b1000;
        tick(); clear_inputs();
        check("R12 set wins", st(3), 4'b1000);
        reg_write(1'b1, 3, 4'b1000);
        check("R12 later clear", st(3), 4'b0000);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_operr();
        t_defer();
        t_ioc();
        t_share();
        t_merge();
        t_setwins();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule